// File: doc/BRIEF.md
# In-Order Retirement Tracker with Deferred Faults

This block keeps the program order of instructions in flight in an out-of-order core. A rename stage allocates one entry per cycle at the tail and gets a tag back. Execution units later report completion for a tag on one of several completion ports. A report may carry a fault or a branch mispredict. Entries leave from the head strictly in order. Each cycle an oldest-first group of up to `RET_W` finished entries is offered on the retire port.

A fault is only recorded when it is reported. It is acted on when the entry becomes the oldest. At that point the entry is not retired: every entry is discarded and a flush naming that tag is raised. A mispredict does not wait for retirement. One cycle after the report, the younger entries are cut off and the branch tag is sent out as a redirect. The older entries stay, even if they are still unfinished. An external flush input empties the buffer at any time.

The allocate port is valid/ready. A beat transfers when `alloc_valid_i && alloc_ready_o` are both high at a clock edge. `alloc_ready_o` does not depend on `alloc_valid_i`. The retire port is valid/ready as a group. `ret_valid_o` never depends on `ret_ready_i`, and the whole offered group is taken at an edge with `ret_ready_i` high. While `ret_ready_i` is low, the oldest offered entry stays offered and more lanes may join the group. Only a flush withdraws the group. Completion, flush and redirect pins are plain signals with no back-pressure.

Top module: `rob_core`

## Requirements
- R1: After reset the first allocated tag is 0. Each accepted allocation returns the tag one above the last, modulo 2^(log2(DEPTH)+1). `alloc_ready_o` is high exactly when the buffer is not full, no mispredict recovery is pending, and no flush is taking place in that cycle.
- R2: After DEPTH allocations with no retirement, `occupancy_o` equals DEPTH and `alloc_ready_o` is low. The occupancy never exceeds DEPTH.
- R3: The group in `ret_valid_o` is filled from bit 0 upward with no gaps. Lane i carries tag head+i. The group ends at the first unfinished entry or after RET_W lanes. Entries leave only at edges with `ret_ready_i` high, and the head advances by the group size.
- R4: After reset, and whenever nothing is in flight, `empty_o` is 1, `occupancy_o` is 0 and `ret_valid_o` is 0.
- R5: An entry reported with a fault is never retired, and it has no effect while older entries remain. In the cycle it is the oldest, nothing is offered and `alloc_ready_o` is low. At the next edge `flush_valid_o` pulses for one cycle with `flush_cause_o` = 1 and `flush_tag_o` = its tag, and the buffer is empty.
- R6: A mispredict reported on a live entry makes `alloc_ready_o` low in the following cycle. At the edge after that, `redirect_valid_o` pulses for one cycle with `redirect_tag_o` = the branch tag. The occupancy then equals branch tag − head + 1. Entries younger than the branch are never offered. Older unfinished entries remain and retire later.
- R7: Only the oldest mispredict takes effect. This holds when several ports report one in the same cycle. It also holds when an older one arrives while a younger one is pending, in which case the older one replaces it and the redirect comes one cycle later. A report younger than the pending one is dropped.
- R8: With `ext_flush_i` high, nothing is offered and `alloc_ready_o` is low in that cycle. At the next edge `flush_valid_o` pulses with `flush_cause_o` = 0 and `flush_tag_o` = the head tag at that time. The buffer becomes empty, and the next allocated tag continues from the old tail.
- R9: Tags carry one wrap bit above the slot index. Ordering and retirement stay correct as tags wrap from 2·DEPTH−1 to 0 several times.
- R10: A completion report whose tag is not in flight is ignored: it starts no recovery, raises no redirect and changes no occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Rename stage offers one instruction |
| alloc_ready_o | output | 1 | Buffer accepts an allocation this cycle |
| alloc_tag_o | output | TAG_W | Tag the next accepted allocation receives |
| cmp_valid_i | input | NUM_CMP | Per-port completion report valid |
| cmp_tag_i | input | NUM_CMP x TAG_W | Per-port tag of the completed entry |
| cmp_fault_i | input | NUM_CMP | Per-port fault-on-retire marker |
| cmp_mispred_i | input | NUM_CMP | Per-port branch mispredict marker |
| ret_valid_o | output | RET_W | Retire lanes offered, oldest in bit 0 |
| ret_tag_o | output | RET_W x TAG_W | Tag of each retire lane |
| ret_ready_i | input | 1 | Commit side takes the offered group |
| ext_flush_i | input | 1 | Discard everything in flight |
| flush_valid_o | output | 1 | One-cycle flush pulse |
| flush_cause_o | output | 1 | 1 = fault at head, 0 = external request |
| flush_tag_o | output | TAG_W | Oldest tag at the time of the flush |
| redirect_valid_o | output | 1 | One-cycle mispredict recovery pulse |
| redirect_tag_o | output | TAG_W | Tag of the mispredicted branch |
| occupancy_o | output | TAG_W | Entries in flight |
| empty_o | output | 1 | No entry in flight |

## Verification
The hardest situation to reach from the ports is two recoveries competing inside the single cycle a recovery stays pending. The stimulus gets there in three ways. It reports a mispredict on one entry and an older one on the very next cycle. It reports two mispredicts on separate ports in the same cycle. It reports a younger one in the cycle the older one is being applied. Retirement order is then swept over every completion order of a full small buffer, with stalls on the retire port mixed in, while the tags wrap around several times.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // reason reported with a flush pulse
  typedef enum logic {
    CAUSE_EXT   = 1'b0,
    CAUSE_FAULT = 1'b1
  } flush_cause_e;
endpackage

// File: rtl/rob_entry_state.sv
// Per-slot done and fault-on-retire flags.
module rob_entry_state #(
  parameter  int DEPTH   = 8,
  parameter  int NUM_CMP = 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_fire_i,
  input  logic [IDX_W-1:0]                alloc_idx_i,
  input  logic [NUM_CMP-1:0]              cmp_hit_i,
  input  logic [NUM_CMP-1:0][IDX_W-1:0]   cmp_idx_i,
  input  logic [NUM_CMP-1:0]              cmp_fault_i,
  output logic [DEPTH-1:0]                done_o,
  output logic [DEPTH-1:0]                fault_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic set_done, set_fault;
    logic done_q, fault_q;

    always_comb begin
      set_done  = 1'b0;
      set_fault = 1'b0;
      for (int p = 0; p < NUM_CMP; p++) begin
        if (cmp_hit_i[p] && (cmp_idx_i[p] == IDX_W'(e))) begin
          set_done  = 1'b1;
          set_fault = set_fault | cmp_fault_i[p];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q  <= 1'b0;
        fault_q <= 1'b0;
      end else if (alloc_fire_i && (alloc_idx_i == IDX_W'(e))) begin
        done_q  <= 1'b0;
        fault_q <= 1'b0;
      end else if (set_done) begin
        done_q  <= 1'b1;
        fault_q <= fault_q | set_fault;
      end
    end

    assign done_o[e]  = done_q;
    assign fault_o[e] = fault_q;

    // R10: a report only lands on an in-flight slot, never on the one being allocated
    a_r10_no_hit_on_free: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire_i && (alloc_idx_i == IDX_W'(e))) |-> !set_done);
  end

endmodule

// File: rtl/rob_retire_sel.sv
// Picks the oldest contiguous run of finished, fault-free entries.
module rob_retire_sel #(
  parameter  int DEPTH = 8,
  parameter  int RET_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = IDX_W + 1
) (
  input  logic [TAG_W-1:0]             head_i,
  input  logic [TAG_W-1:0]             avail_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0]             fault_i,
  output logic [RET_W-1:0]             ret_valid_o,
  output logic [RET_W-1:0][TAG_W-1:0]  ret_tag_o,
  output logic                         fault_head_o
);

  logic             run;
  logic [TAG_W-1:0] tg;
  logic [IDX_W-1:0] hidx;

  always_comb begin
    run = 1'b1;
    tg  = head_i;
    for (int i = 0; i < RET_W; i++) begin
      tg             = head_i + TAG_W'(i);
      ret_tag_o[i]   = tg;
      ret_valid_o[i] = run && (TAG_W'(i) < avail_i) &&
                       done_i[tg[IDX_W-1:0]] && !fault_i[tg[IDX_W-1:0]];
      run            = ret_valid_o[i];
    end
  end

  assign hidx         = head_i[IDX_W-1:0];
  assign fault_head_o = (avail_i != '0) && done_i[hidx] && fault_i[hidx];

endmodule

// File: rtl/rob_recover_arb.sv
// Chooses the oldest mispredict among the pending one and new reports,
// and marks which reports name in-flight entries.
module rob_recover_arb #(
  parameter int NUM_CMP = 2,
  parameter int TAG_W   = 4
) (
  input  logic [TAG_W-1:0]               head_i,
  input  logic [TAG_W-1:0]               count_i,
  input  logic                           pend_v_i,
  input  logic [TAG_W-1:0]               pend_tag_i,
  input  logic [NUM_CMP-1:0]             cmp_valid_i,
  input  logic [NUM_CMP-1:0][TAG_W-1:0]  cmp_tag_i,
  input  logic [NUM_CMP-1:0]             cmp_mis_i,
  output logic [NUM_CMP-1:0]             cmp_live_o,
  output logic                           take_new_o,
  output logic [TAG_W-1:0]               new_tag_o,
  output logic                           apply_pend_o
);

  logic             best_v;
  logic [TAG_W-1:0] best_age;
  logic [TAG_W-1:0] age;

  always_comb begin
    best_v     = pend_v_i;
    best_age   = pend_tag_i - head_i;
    new_tag_o  = pend_tag_i;
    take_new_o = 1'b0;
    age        = '0;
    for (int p = 0; p < NUM_CMP; p++) begin
      age           = cmp_tag_i[p] - head_i;
      cmp_live_o[p] = cmp_valid_i[p] && (age < count_i);
      if (cmp_live_o[p] && cmp_mis_i[p] && (!best_v || (age < best_age))) begin
        best_v     = 1'b1;
        best_age   = age;
        new_tag_o  = cmp_tag_i[p];
        take_new_o = 1'b1;
      end
    end
    apply_pend_o = pend_v_i && !take_new_o;
  end

endmodule

// File: rtl/rob_core.sv
// In-order retirement tracker: circular buffer, deferred faults,
// early mispredict squash, external flush.
module rob_core #(
  parameter  int DEPTH   = 8,
  parameter  int RET_W   = 2,
  parameter  int NUM_CMP = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int TAG_W   = IDX_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_valid_i,
  output logic                            alloc_ready_o,
  output logic [TAG_W-1:0]                alloc_tag_o,
  input  logic [NUM_CMP-1:0]              cmp_valid_i,
  input  logic [NUM_CMP-1:0][TAG_W-1:0]   cmp_tag_i,
  input  logic [NUM_CMP-1:0]              cmp_fault_i,
  input  logic [NUM_CMP-1:0]              cmp_mispred_i,
  output logic [RET_W-1:0]                ret_valid_o,
  output logic [RET_W-1:0][TAG_W-1:0]     ret_tag_o,
  input  logic                            ret_ready_i,
  input  logic                            ext_flush_i,
  output logic                            flush_valid_o,
  output logic                            flush_cause_o,
  output logic [TAG_W-1:0]                flush_tag_o,
  output logic                            redirect_valid_o,
  output logic [TAG_W-1:0]                redirect_tag_o,
  output logic [TAG_W-1:0]                occupancy_o,
  output logic                            empty_o
);

  logic [TAG_W-1:0] head_q, tail_q, pend_tag_q;
  logic             pend_v_q;
  rob_pkg::flush_cause_e cause_q;

  logic [TAG_W-1:0] count, avail, n_ret, new_tag;
  logic             full, flush_now, fault_head, ret_fire, alloc_fire;
  logic             take_new, apply_pend;
  logic [DEPTH-1:0] done_v, fault_v;
  logic [RET_W-1:0] sel_valid;
  logic [NUM_CMP-1:0]            cmp_live, cmp_hit;
  logic [NUM_CMP-1:0][IDX_W-1:0] cmp_idx;

  assign count       = tail_q - head_q;
  assign full        = (count == TAG_W'(DEPTH));
  // while a recovery is pending, nothing past the branch may leave
  assign avail       = pend_v_q ? (pend_tag_q - head_q + TAG_W'(1)) : count;
  assign occupancy_o = count;
  assign empty_o     = (count == '0);

  rob_recover_arb #(.NUM_CMP(NUM_CMP), .TAG_W(TAG_W)) u_arb (
    .head_i      (head_q),
    .count_i     (count),
    .pend_v_i    (pend_v_q),
    .pend_tag_i  (pend_tag_q),
    .cmp_valid_i (cmp_valid_i),
    .cmp_tag_i   (cmp_tag_i),
    .cmp_mis_i   (cmp_mispred_i),
    .cmp_live_o  (cmp_live),
    .take_new_o  (take_new),
    .new_tag_o   (new_tag),
    .apply_pend_o(apply_pend)
  );

  rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) u_sel (
    .head_i      (head_q),
    .avail_i     (avail),
    .done_i      (done_v),
    .fault_i     (fault_v),
    .ret_valid_o (sel_valid),
    .ret_tag_o   (ret_tag_o),
    .fault_head_o(fault_head)
  );

  assign flush_now     = ext_flush_i | fault_head;
  assign ret_valid_o   = flush_now ? '0 : sel_valid;
  assign ret_fire      = ret_ready_i && ret_valid_o[0];
  assign n_ret         = TAG_W'($countones(ret_valid_o));
  assign alloc_ready_o = !full && !pend_v_q && !flush_now;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_tag_o   = tail_q;
  assign cmp_hit       = cmp_live & {NUM_CMP{!flush_now}};
  assign flush_cause_o = cause_q;

  always_comb begin
    for (int p = 0; p < NUM_CMP; p++) cmp_idx[p] = cmp_tag_i[p][IDX_W-1:0];
  end

  rob_entry_state #(.DEPTH(DEPTH), .NUM_CMP(NUM_CMP)) u_ent (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire_i(alloc_fire),
    .alloc_idx_i (tail_q[IDX_W-1:0]),
    .cmp_hit_i   (cmp_hit),
    .cmp_idx_i   (cmp_idx),
    .cmp_fault_i (cmp_fault_i),
    .done_o      (done_v),
    .fault_o     (fault_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q           <= '0;
      tail_q           <= '0;
      pend_v_q         <= 1'b0;
      pend_tag_q       <= '0;
      flush_valid_o    <= 1'b0;
      flush_tag_o      <= '0;
      cause_q          <= rob_pkg::CAUSE_EXT;
      redirect_valid_o <= 1'b0;
      redirect_tag_o   <= '0;
    end else begin
      flush_valid_o    <= 1'b0;
      redirect_valid_o <= 1'b0;
      if (flush_now) begin
        head_q        <= tail_q;
        pend_v_q      <= 1'b0;
        flush_valid_o <= 1'b1;
        flush_tag_o   <= head_q;
        cause_q       <= fault_head ? rob_pkg::CAUSE_FAULT : rob_pkg::CAUSE_EXT;
      end else begin
        if (ret_fire)   head_q <= head_q + n_ret;
        if (alloc_fire) tail_q <= tail_q + TAG_W'(1);
        if (take_new) begin
          pend_v_q   <= 1'b1;
          pend_tag_q <= new_tag;
        end else if (apply_pend) begin
          pend_v_q         <= 1'b0;
          tail_q           <= pend_tag_q + TAG_W'(1);
          redirect_valid_o <= 1'b1;
          redirect_tag_o   <= pend_tag_q;
        end
      end
    end
  end

  // R2: the window never holds more than DEPTH entries
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy_o <= TAG_W'(DEPTH));

  // R3: offered lanes form an unbroken run starting at the oldest
  a_r3_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid_o & (ret_valid_o + RET_W'(1))) == '0);

  // R4: nothing is offered from an empty buffer
  a_r4_empty_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (ret_valid_o == '0));

  // R5: a flush pulse always leaves the buffer empty
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid_o |-> empty_o);

  // R6: after a redirect the branch is the youngest entry
  a_r6_redirect_tail: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> ((tail_q - redirect_tag_o) == TAG_W'(1)));

  // R7: the pending recovery always names an in-flight entry
  a_r7_pend_live: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> ((pend_tag_q - head_q) < count));

  // R8: an external flush empties the buffer at the next edge
  a_r8_ext_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ext_flush_i |=> (flush_valid_o && empty_o));

endmodule

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
  localparam int DEPTH   = 4;
  localparam int RET_W   = 2;
  localparam int NUM_CMP = 2;
  localparam int TAG_W   = 3;
  localparam int TMOD    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                          alloc_valid, alloc_ready;
  logic [TAG_W-1:0]              alloc_tag;
  logic [NUM_CMP-1:0]            cmp_valid, cmp_fault, cmp_mis;
  logic [NUM_CMP-1:0][TAG_W-1:0] cmp_tag;
  logic [RET_W-1:0]              ret_valid;
  logic [RET_W-1:0][TAG_W-1:0]   ret_tag;
  logic                          ret_ready, ext_flush;
  logic                          flush_valid, flush_cause, redirect_valid, empty;
  logic [TAG_W-1:0]              flush_tag, redirect_tag, occupancy;

  rob_core #(.DEPTH(DEPTH), .RET_W(RET_W), .NUM_CMP(NUM_CMP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
    .cmp_valid_i(cmp_valid), .cmp_tag_i(cmp_tag), .cmp_fault_i(cmp_fault),
    .cmp_mispred_i(cmp_mis),
    .ret_valid_o(ret_valid), .ret_tag_o(ret_tag), .ret_ready_i(ret_ready),
    .ext_flush_i(ext_flush),
    .flush_valid_o(flush_valid), .flush_cause_o(flush_cause), .flush_tag_o(flush_tag),
    .redirect_valid_o(redirect_valid), .redirect_tag_o(redirect_tag),
    .occupancy_o(occupancy), .empty_o(empty)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int m_tail = 0;

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic clr_cmp();
    cmp_valid = '0; cmp_fault = '0; cmp_mis = '0; cmp_tag = '0;
  endtask

  task automatic rpt(input int port, input int tag, input bit flt, input bit mis);
    cmp_valid[port] = 1'b1;
    cmp_tag[port]   = TAG_W'(tag % TMOD);
    cmp_fault[port] = flt;
    cmp_mis[port]   = mis;
  endtask

  task automatic alloc_n(input int n);
    for (int k = 0; k < n; k++) begin
      chk(alloc_ready, 1, "R1", "alloc ready");
      chk(alloc_tag, m_tail % TMOD, "R1", "alloc tag");
      alloc_valid = 1'b1;
      step();
      alloc_valid = 1'b0;
      m_tail = (m_tail + 1) % TMOD;
    end
  endtask

  // every completion order of a full buffer, with retire stalls mixed in
  task automatic sweep_orders();
    int fact [4];
    int pool [4];
    int order [4];
    bit dn [4];
    int r, sel, base, hptr, issued, n, cyc;
    bit rdy;
    fact = '{6, 2, 1, 1};
    for (int p = 0; p < 24; p++) begin
      pool = '{0, 1, 2, 3};
      r = p;
      for (int k = 0; k < 4; k++) begin
        sel = r / fact[k];
        r = r % fact[k];
        order[k] = pool[sel];
        for (int j = sel; j < 3; j++) pool[j] = pool[j+1];
      end
      base = m_tail;
      alloc_n(4);
      chk(alloc_ready, 0, "R2", "full stalls allocation");
      chk(occupancy, 4, "R2", "full occupancy");
      dn = '{0, 0, 0, 0};
      hptr = 0; issued = 0; cyc = 0;
      while (hptr < 4 && cyc < 40) begin
        rdy = !((p % 2 == 1) && (cyc % 3 == 1));
        ret_ready = rdy;
        n = 0;
        while (n < RET_W && (hptr + n) < 4 && dn[hptr + n]) n++;
        chk(ret_valid, (1 << n) - 1, "R3", "retire group");
        if (n > 0) chk(ret_tag[0], (base + hptr) % TMOD, "R9", "lane0 tag");
        if (n > 1) chk(ret_tag[1], (base + hptr + 1) % TMOD, "R9", "lane1 tag");
        clr_cmp();
        if (issued < 4) rpt(0, base + order[issued], 1'b0, 1'b0);
        step();
        if (rdy) hptr += n;
        if (issued < 4) begin
          dn[order[issued]] = 1'b1;
          issued++;
        end
        cyc++;
      end
      clr_cmp();
      ret_ready = 1'b1;
      chk(empty, 1, "R4", "empty after sweep order");
    end
  endtask

  initial begin
    int b;
    alloc_valid = 1'b0; ret_ready = 1'b1; ext_flush = 1'b0;
    clr_cmp();
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    // R4 reset state
    chk(empty, 1, "R4", "reset empty");
    chk(occupancy, 0, "R4", "reset occupancy");
    chk(ret_valid, 0, "R4", "reset retire");
    chk(flush_valid, 0, "R4", "reset flush");
    chk(redirect_valid, 0, "R4", "reset redirect");
    chk(alloc_tag, 0, "R1", "first tag");

    sweep_orders();

    // R5 deferred fault
    b = m_tail;
    alloc_n(3);
    rpt(0, b + 1, 1'b1, 1'b0); step(); clr_cmp();
    chk(ret_valid, 0, "R5", "older unfinished blocks");
    chk(flush_valid, 0, "R5", "no early flush");
    rpt(0, b, 1'b0, 1'b0); step(); clr_cmp();
    chk(ret_valid, 1, "R5", "older entry retires, faulty held");
    chk(flush_valid, 0, "R5", "no flush before head");
    step();
    chk(ret_valid, 0, "R5", "faulty head not retired");
    chk(alloc_ready, 0, "R5", "no alloc during fault");
    step();
    chk(flush_valid, 1, "R5", "flush pulse");
    chk(flush_cause, 1, "R5", "cause fault");
    chk(flush_tag, (b + 1) % TMOD, "R5", "flush tag");
    chk(empty, 1, "R5", "empty after fault");
    step();
    chk(flush_valid, 0, "R5", "flush one cycle");

    // R6 early squash
    b = m_tail;
    alloc_n(4);
    rpt(0, b + 1, 1'b0, 1'b1); rpt(1, b + 3, 1'b0, 1'b0); step(); clr_cmp();
    chk(alloc_ready, 0, "R6", "alloc held while pending");
    chk(redirect_valid, 0, "R6", "redirect not yet");
    chk(occupancy, 4, "R6", "occupancy while pending");
    chk(ret_valid, 0, "R6", "oldest still unfinished");
    step();
    chk(redirect_valid, 1, "R6", "redirect pulse");
    chk(redirect_tag, (b + 1) % TMOD, "R6", "redirect tag");
    chk(occupancy, 2, "R6", "younger squashed");
    chk(alloc_ready, 1, "R6", "alloc resumes");
    m_tail = (b + 2) % TMOD;
    chk(alloc_tag, m_tail, "R6", "tail after branch");
    rpt(0, b, 1'b0, 1'b0); step(); clr_cmp();
    chk(ret_valid, 3, "R6", "older and branch retire");
    chk(ret_tag[1], (b + 1) % TMOD, "R6", "branch lane");
    step();
    chk(empty, 1, "R6", "squashed entry never retires");
    chk(redirect_valid, 0, "R6", "redirect one cycle");

    // R7 oldest recovery wins
    b = m_tail;
    alloc_n(4);
    rpt(0, b + 2, 1'b0, 1'b1); step(); clr_cmp();
    rpt(1, b + 1, 1'b0, 1'b1); step(); clr_cmp();
    chk(redirect_valid, 0, "R7", "older replaces pending");
    chk(occupancy, 4, "R7", "no squash yet");
    step();
    chk(redirect_valid, 1, "R7", "replaced redirect");
    chk(redirect_tag, (b + 1) % TMOD, "R7", "older tag wins");
    chk(occupancy, 2, "R7", "cut after older");
    m_tail = (b + 2) % TMOD;
    alloc_n(2);
    rpt(0, b + 3, 1'b0, 1'b1); rpt(1, b + 2, 1'b0, 1'b1); step(); clr_cmp();
    step();
    chk(redirect_tag, (b + 2) % TMOD, "R7", "same-cycle oldest wins");
    chk(occupancy, 3, "R7", "same-cycle occupancy");
    m_tail = (b + 3) % TMOD;
    rpt(0, b + 1, 1'b0, 1'b1); step(); clr_cmp();
    rpt(0, b + 2, 1'b0, 1'b1); step(); clr_cmp();
    chk(redirect_valid, 1, "R7", "pending applied");
    chk(redirect_tag, (b + 1) % TMOD, "R7", "younger dropped");
    chk(occupancy, 2, "R7", "occupancy after drop");
    m_tail = (b + 2) % TMOD;
    step();
    chk(redirect_valid, 0, "R7", "no second redirect");
    rpt(0, b, 1'b0, 1'b0); step(); clr_cmp();
    step();
    chk(empty, 1, "R7", "drained");

    // R8 external flush
    b = m_tail;
    alloc_n(3);
    rpt(0, b, 1'b0, 1'b0); step(); clr_cmp();
    chk(ret_valid, 1, "R8", "group offered before flush");
    ret_ready = 1'b0;
    ext_flush = 1'b1;
    #1;
    chk(ret_valid, 0, "R8", "nothing offered during flush");
    chk(alloc_ready, 0, "R8", "no alloc during flush");
    step();
    ext_flush = 1'b0;
    ret_ready = 1'b1;
    chk(flush_valid, 1, "R8", "flush pulse");
    chk(flush_cause, 0, "R8", "cause external");
    chk(flush_tag, b % TMOD, "R8", "flush tag is head");
    chk(empty, 1, "R8", "empty after flush");
    chk(alloc_tag, (b + 3) % TMOD, "R8", "tags continue");
    m_tail = (b + 3) % TMOD;

    // R10 stale reports
    rpt(0, b + 1, 1'b0, 1'b1); step(); clr_cmp();
    chk(alloc_ready, 1, "R10", "stale mispredict starts no recovery");
    step();
    chk(redirect_valid, 0, "R10", "stale mispredict no redirect");
    chk(empty, 1, "R10", "still empty");
    b = m_tail;
    alloc_n(2);
    rpt(0, b + 2, 1'b0, 1'b1); step(); clr_cmp();
    chk(alloc_ready, 1, "R10", "unallocated tag ignored");
    step();
    chk(redirect_valid, 0, "R10", "unallocated tag no redirect");
    chk(occupancy, 2, "R10", "occupancy unchanged");
    rpt(0, b, 1'b0, 1'b0); rpt(1, b + 1, 1'b0, 1'b0); step(); clr_cmp();
    chk(ret_valid, 3, "R3", "two lanes at once");
    step();
    chk(empty, 1, "R4", "final drain");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL all watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule